// File: doc/BRIEF.md
# Two-Accumulator 8-bit Processor Core

A compact multi-cycle processor core with two 8-bit accumulators (A and B), a 16-bit program counter, an instruction register and a four-bit status register holding negative, zero, overflow and carry. It talks to a single byte-wide memory through a 16-bit address bus. Read data comes back one cycle after the address is presented, and writes take effect on a single-cycle write strobe. The core has no output instructions. A program makes its results visible by storing them to a memory location it has chosen.

After reset the core reads a 16-bit start address from the top two bytes of the address space, high byte first. It then loops over fetch, decode, operand fetch and execute. The program counter is moved past every byte of an instruction before that instruction executes, so relative branches are measured from the following instruction. The instruction subset is enough to run small counting and arithmetic loops such as a mod-(N+1) counter.

The controller has seven named states:
- VEC_HI: presents $FFFE.
- VEC_LO: presents $FFFF and latches the high byte.
- VEC_LD: loads the program counter.
- FETCH: presents the program counter and increments it.
- DECODE: latches the opcode and moves to OPND for a two-byte instruction, or to EXEC otherwise.
- OPND: latches the operand byte and, for a direct read, presents the zero-page address.
- EXEC: performs the operation, then returns to FETCH.

Top module: `cpu8_core`

## Requirements
- R1: Reset behaviour. While reset is held, the address bus shows $FFFE, the write strobe is low and the status flags are 0000. After release the core reads $FFFE, then $FFFF, and starts fetching at {M[$FFFE], M[$FFFF]}.
- R2: Fetch and length. The opcode byte is fetched first. A two-byte instruction then fetches its operand byte from the next address. The program counter ends past the whole instruction (one or two bytes) before execute. Every two-byte instruction takes 4 cycles and every one-byte instruction takes 3.
- R3: Loads. Opcodes $86 and $96 load A; opcodes $C6 and $D6 load B. The first opcode of each pair takes an immediate operand; the second reads M[$00nn]. A load sets N and Z from the value, clears V and keeps C.
- R4: Stores. Opcodes $5A (A) and $5B (B) write the accumulator to M[$00nn] with a write strobe that lasts exactly one cycle. A store sets N and Z from the stored value, clears V and keeps C.
- R5: Additions. $8B/$9B add an immediate or direct operand into A, and $CB/$DB do the same into B. The two-byte sequence $18 $06 adds B into A. An addition sets C to the carry out, V to the signed overflow, and N and Z from the result.
- R6: Subtractions. $80/$90 subtract an immediate or direct operand from A, and $C0/$D0 subtract it from B. C is set as the borrow (1 when the operand is larger, unsigned), V as the signed overflow, and N and Z from the result.
- R7: Compare. $81/$91 set the flags exactly as the matching subtraction from A would, and leave A unchanged.
- R8: Clear-A. $87 sets A to 0 and the flags to N=0, Z=1, V=0, C=0.
- R9: Branches. $20 always branches and $27 branches only when Z=1. The target is the address after the two-byte branch plus the sign-extended offset byte. Branches leave the flags unchanged.
- R10: Unknown opcodes. Any unknown opcode, and $18 followed by anything other than $06, executes as a no-op. It writes no memory and changes no register or flag. An unknown opcode occupies one byte.
- R11: Flag output. The port `cc_flags` shows the flags with N in bit 3, Z in bit 2, V in bit 1 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe, one cycle per store |
| mem_rdata | input | 8 | Read data for the address presented in the previous cycle |
| cc_flags | output | 4 | Status flags {N, Z, V, C} |

## Verification
The assertions assume a memory that returns, one cycle later, the byte at the address presented, and that reset is held for at least one clock edge. The bench memory is a registered array that keeps exactly this one-cycle latency. Reset is always asserted across several edges before a program is loaded. Programs are written so that every opcode and operand byte lands where the core's fetch order expects it, and each program ends in a branch-to-self so the core never runs into uninitialised memory.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam logic [AW-1:0] VECTOR_ADDR = {AW{1'b1}} - 1'b1;

    typedef enum logic [2:0] {
        ST_VEC_HI, ST_VEC_LO, ST_VEC_LD, ST_FETCH, ST_DECODE, ST_OPND, ST_EXEC
    } state_e;

    typedef enum logic [3:0] {
        K_NOP, K_LD, K_ST, K_ADD, K_SUB, K_CMP, K_ABA, K_CLRA, K_BEQ, K_BRA
    } kind_e;

    typedef enum logic [1:0] {M_NONE, M_IMM, M_DIR, M_REL} mode_e;

    typedef struct packed {
        kind_e kind;
        logic  use_b;
        mode_e mode;
    } dec_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_PASS, ALU_CLR} alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  logic [DW-1:0] opc,
    output dec_t          dec
);
    always_comb begin
        dec.kind  = K_NOP;
        dec.use_b = 1'b0;
        dec.mode  = M_NONE;
        case (opc)
            8'h86: begin dec.kind = K_LD;  dec.mode = M_IMM; end
            8'h96: begin dec.kind = K_LD;  dec.mode = M_DIR; end
            8'hC6: begin dec.kind = K_LD;  dec.mode = M_IMM; dec.use_b = 1'b1; end
            8'hD6: begin dec.kind = K_LD;  dec.mode = M_DIR; dec.use_b = 1'b1; end
            8'h5A: begin dec.kind = K_ST;  dec.mode = M_DIR; end
            8'h5B: begin dec.kind = K_ST;  dec.mode = M_DIR; dec.use_b = 1'b1; end
            8'h18: begin dec.kind = K_ABA; dec.mode = M_IMM; end
            8'h8B: begin dec.kind = K_ADD; dec.mode = M_IMM; end
            8'h9B: begin dec.kind = K_ADD; dec.mode = M_DIR; end
            8'hCB: begin dec.kind = K_ADD; dec.mode = M_IMM; dec.use_b = 1'b1; end
            8'hDB: begin dec.kind = K_ADD; dec.mode = M_DIR; dec.use_b = 1'b1; end
            8'h80: begin dec.kind = K_SUB; dec.mode = M_IMM; end
            8'h90: begin dec.kind = K_SUB; dec.mode = M_DIR; end
            8'hC0: begin dec.kind = K_SUB; dec.mode = M_IMM; dec.use_b = 1'b1; end
            8'hD0: begin dec.kind = K_SUB; dec.mode = M_DIR; dec.use_b = 1'b1; end
            8'h81: begin dec.kind = K_CMP; dec.mode = M_IMM; end
            8'h91: begin dec.kind = K_CMP; dec.mode = M_DIR; end
            8'h87: begin dec.kind = K_CLRA; end
            8'h27: begin dec.kind = K_BEQ; dec.mode = M_REL; end
            8'h20: begin dec.kind = K_BRA; dec.mode = M_REL; end
            default: begin dec.kind = K_NOP; end
        endcase
    end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  flags_t       fl_in,
    output logic [W-1:0] res,
    output flags_t       fl_out
);
    logic [W:0] sum_w;
    logic [W:0] dif_w;

    always_comb begin
        sum_w = {1'b0, x} + {1'b0, y};
        dif_w = {1'b0, x} - {1'b0, y};
        res   = '0;
        fl_out = fl_in;
        case (op)
            ALU_ADD: begin
                res      = sum_w[W-1:0];
                fl_out.c = sum_w[W];
                fl_out.v = (x[W-1] == y[W-1]) && (res[W-1] != x[W-1]);
            end
            ALU_SUB: begin
                res      = dif_w[W-1:0];
                fl_out.c = dif_w[W];
                fl_out.v = (x[W-1] != y[W-1]) && (res[W-1] != x[W-1]);
            end
            ALU_PASS: begin
                res      = y;
                fl_out.v = 1'b0;
            end
            default: begin
                res      = '0;
                fl_out.c = 1'b0;
                fl_out.v = 1'b0;
            end
        endcase
        fl_out.n = res[W-1];
        fl_out.z = (res == '0);
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata,
    output logic [3:0]    cc_flags
);
    localparam int PAD = AW - DW;

    state_e          state, state_nx;
    logic [AW-1:0]   pc;
    logic [DW-1:0]   ir, opnd, acc_a, acc_b, vec_hi;
    flags_t          flags;

    logic [DW-1:0]   opc_src, opv, alu_x, alu_y, alu_res;
    dec_t            dec;
    alu_op_e         alu_op;
    flags_t          alu_fl;
    logic            dir_read, is_store, two_byte;

    assign opc_src = (state == ST_DECODE) ? mem_rdata : ir;

    cpu8_decode u_dec (.opc(opc_src), .dec(dec));

    assign dir_read = (dec.mode == M_DIR) && (dec.kind != K_ST);
    assign is_store = (dec.kind == K_ST);
    assign two_byte = (dec.mode != M_NONE);
    assign opv      = (dec.mode == M_DIR) ? mem_rdata : opnd;

    always_comb begin
        case (dec.kind)
            K_ADD, K_ABA: alu_op = ALU_ADD;
            K_SUB, K_CMP: alu_op = ALU_SUB;
            K_CLRA:       alu_op = ALU_CLR;
            default:      alu_op = ALU_PASS;
        endcase
        alu_x = dec.use_b ? acc_b : acc_a;
        if (dec.kind == K_ABA)     alu_y = acc_b;
        else if (is_store)         alu_y = alu_x;
        else                       alu_y = opv;
    end

    cpu8_alu #(.W(DW)) u_alu (
        .op(alu_op), .x(alu_x), .y(alu_y), .fl_in(flags),
        .res(alu_res), .fl_out(alu_fl)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_VEC_HI;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        unique case (state)
            ST_VEC_HI: state_nx = ST_VEC_LO;
            ST_VEC_LO: state_nx = ST_VEC_LD;
            ST_VEC_LD: state_nx = ST_FETCH;
            ST_FETCH:  state_nx = ST_DECODE;
            ST_DECODE: state_nx = two_byte ? ST_OPND : ST_EXEC;
            ST_OPND:   state_nx = ST_EXEC;
            ST_EXEC:   state_nx = ST_FETCH;
            default:   state_nx = ST_VEC_HI;
        endcase
    end

    // memory-side outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = alu_x;
        unique case (state)
            ST_VEC_HI: mem_addr = VECTOR_ADDR;
            ST_VEC_LO: mem_addr = VECTOR_ADDR + 1'b1;
            ST_OPND:   mem_addr = dir_read ? {{PAD{1'b0}}, mem_rdata} : pc;
            ST_EXEC: begin
                mem_addr = is_store ? {{PAD{1'b0}}, opnd} : pc;
                mem_we   = is_store;
            end
            default:   mem_addr = pc;
        endcase
    end

    assign cc_flags = flags;

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; ir <= '0; opnd <= '0; vec_hi <= '0;
            acc_a <= '0; acc_b <= '0; flags <= '0;
        end else begin
            unique case (state)
                ST_VEC_LO: vec_hi <= mem_rdata;
                ST_VEC_LD: pc <= {vec_hi, mem_rdata};
                ST_FETCH:  pc <= pc + 1'b1;
                ST_DECODE: begin
                    ir <= mem_rdata;
                    if (two_byte) pc <= pc + 1'b1;
                end
                ST_OPND:   opnd <= mem_rdata;
                ST_EXEC: begin
                    case (dec.kind)
                        K_LD, K_ADD, K_SUB: begin
                            if (dec.use_b) acc_b <= alu_res;
                            else           acc_a <= alu_res;
                            flags <= alu_fl;
                        end
                        K_ST, K_CMP: flags <= alu_fl;
                        K_ABA: if (opnd == 8'h06) begin
                            acc_a <= alu_res;
                            flags <= alu_fl;
                        end
                        K_CLRA: begin
                            acc_a <= alu_res;
                            flags <= alu_fl;
                        end
                        K_BRA: pc <= pc + {{PAD{opnd[DW-1]}}, opnd};
                        K_BEQ: if (flags.z) pc <= pc + {{PAD{opnd[DW-1]}}, opnd};
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // ---------------- assertions ----------------
    assert_vector_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VEC_LD) |=> (mem_addr == {$past(vec_hi), $past(mem_rdata)}));

    assert_fetch_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

    assert_store_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_store_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc_a || mem_wdata == acc_b));

    assert_clra_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.kind == K_CLRA) |=> (acc_a == '0 && cc_flags == 4'b0100));

    assert_beq_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.kind == K_BEQ && !flags.z) |=> (pc == $past(pc)));

    assert_branch_keeps_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && (dec.kind == K_BEQ || dec.kind == K_BRA)) |=> $stable(cc_flags));

    assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && dec.kind == K_NOP) |=> ($stable(acc_a) && $stable(acc_b) && $stable(cc_flags)));

endmodule

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata;
    logic [3:0]  cc_flags;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    cpu8_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .cc_flags(cc_flags)
    );

    // 1 KB memory aliased across the 64 KB space; read latency one cycle
    logic [7:0] mem [1024];
    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr[9:0]];
        if (mem_we) mem[mem_addr[9:0]] = mem_wdata;
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [7:0] v);
        mem[a[9:0]] = v;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
    endtask

    task automatic release_run(input int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    // table: {a, b, opcode, operand, M[$40], expected A, expected C}
    localparam int NV = 13;
    localparam logic [55:0] VEC [NV] = '{
        {8'h11, 8'h00, 8'h86, 8'h80, 8'h00, 8'h80, 8'h00}, // R3 LDAA imm
        {8'h11, 8'h00, 8'h96, 8'h40, 8'h5A, 8'h5A, 8'h00}, // R3 LDAA dir
        {8'hF0, 8'h00, 8'h8B, 8'h20, 8'h00, 8'h10, 8'h01}, // R5 ADDA imm carry
        {8'h01, 8'h00, 8'h9B, 8'h40, 8'hFF, 8'h00, 8'h01}, // R5 ADDA dir zero
        {8'h05, 8'h00, 8'h80, 8'h07, 8'h00, 8'hFE, 8'h01}, // R6 SUBA imm borrow
        {8'h09, 8'h00, 8'h90, 8'h40, 8'h09, 8'h00, 8'h00}, // R6 SUBA dir
        {8'h30, 8'h00, 8'h81, 8'h40, 8'h00, 8'h30, 8'h01}, // R7 CMPA imm
        {8'h50, 8'h00, 8'h91, 8'h40, 8'h10, 8'h50, 8'h00}, // R7 CMPA dir
        {8'h7F, 8'h02, 8'h18, 8'h06, 8'h00, 8'h81, 8'h00}, // R5 ABA
        {8'hC0, 8'h80, 8'h18, 8'h06, 8'h00, 8'h40, 8'h01}, // R5 ABA carry
        {8'hAA, 8'h00, 8'h87, 8'h01, 8'h00, 8'h00, 8'h00}, // R8 CLRA then nop
        {8'h3C, 8'h00, 8'h01, 8'h01, 8'h00, 8'h3C, 8'h00}, // R10 unknown
        {8'h3C, 8'h55, 8'h18, 8'h07, 8'h00, 8'h3C, 8'h00}  // R10 bad ABA tail
    };

    logic       mon_en = 1'b0;
    logic [7:0] exp_cnt = 8'h00;
    int         n_writes = 0;

    always @(negedge clk) begin
        if (mon_en && rst_n && mem_we && mem_addr == 16'h0080) begin
            check("R9 counter value", {8'h00, mem_wdata}, {8'h00, exp_cnt});
            exp_cnt  = (exp_cnt == 8'h0F) ? 8'h00 : exp_cnt + 8'h01;
            n_writes++;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // ---- reset state (R1, R11)
        hold_reset();
        @(negedge clk);
        check("R1 reset address", mem_addr, 16'hFFFE);
        check("R1 reset write strobe", {15'd0, mem_we}, 16'd0);
        check("R11 reset flags", {12'd0, cc_flags}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 second vector read", mem_addr, 16'hFFFF);

        // ---- table walk (R2..R8, R10, R11)
        for (int i = 0; i < NV; i++) begin
            logic [7:0] ea;
            hold_reset();
            poke(16'hFFFE, 8'h02); poke(16'hFFFF, 8'h00);
            poke(16'h0040, VEC[i][23:16]);
            poke(16'h0200, 8'hC6); poke(16'h0201, VEC[i][47:40]);
            poke(16'h0202, 8'h86); poke(16'h0203, VEC[i][55:48]);
            poke(16'h0204, VEC[i][39:32]); poke(16'h0205, VEC[i][31:24]);
            poke(16'h0206, 8'h5A); poke(16'h0207, 8'h80);
            poke(16'h0208, 8'h20); poke(16'h0209, 8'hFE);
            release_run(40);
            ea = VEC[i][15:8];
            check($sformatf("R2 R5 R6 R7 table %0d result", i), {8'h00, mem[16'h0080]}, {8'h00, ea});
            check($sformatf("R4 R11 table %0d flags", i), {12'd0, cc_flags},
                  {12'd0, ea[7], (ea == 8'h00), 1'b0, VEC[i][0]});
        end

        // ---- accumulator B path (R3, R4, R5, R6)
        hold_reset();
        poke(16'hFFFE, 8'h02); poke(16'hFFFF, 8'h00);
        poke(16'h0040, 8'h01);
        begin
            logic [7:0] pb [24] = '{8'hC6,8'h10, 8'hCB,8'hF5, 8'h5B,8'h81, 8'hC0,8'h06,
                                    8'h5B,8'h82, 8'hD6,8'h40, 8'hDB,8'h40, 8'hD0,8'h40,
                                    8'h5B,8'h83, 8'hC0,8'h05, 8'h5B,8'h84, 8'h20,8'hFE};
            for (int k = 0; k < 24; k++) poke(16'h0200 + k, pb[k]);
        end
        release_run(80);
        check("R5 ADDB imm wrap", {8'h00, mem[16'h0081]}, 16'h0005);
        check("R6 SUBB imm borrow", {8'h00, mem[16'h0082]}, 16'h00FF);
        check("R3 R5 R6 LDAB/ADDB/SUBB dir", {8'h00, mem[16'h0083]}, 16'h0001);
        check("R6 SUBB below zero", {8'h00, mem[16'h0084]}, 16'h00FC);
        check("R4 store keeps C", {12'd0, cc_flags}, 16'h0009);

        // ---- signed overflow on add (R5) and subtract (R6)
        hold_reset();
        poke(16'hFFFE, 8'h02); poke(16'hFFFF, 8'h00);
        poke(16'h0200, 8'h86); poke(16'h0201, 8'h7F);
        poke(16'h0202, 8'h8B); poke(16'h0203, 8'h01);
        poke(16'h0204, 8'h20); poke(16'h0205, 8'hFE);
        release_run(30);
        check("R5 add overflow flags", {12'd0, cc_flags}, 16'h000A);

        hold_reset();
        poke(16'hFFFE, 8'h02); poke(16'hFFFF, 8'h00);
        poke(16'h0200, 8'h86); poke(16'h0201, 8'h80);
        poke(16'h0202, 8'h80); poke(16'h0203, 8'h01);
        poke(16'h0204, 8'h20); poke(16'h0205, 8'hFE);
        release_run(30);
        check("R6 sub overflow flags", {12'd0, cc_flags}, 16'h0002);

        // ---- mod-16 counter from a different vector (R1, R7, R9)
        hold_reset();
        poke(16'hFFFE, 8'h03); poke(16'hFFFF, 8'h00);
        poke(16'h0041, 8'h0F); poke(16'h0042, 8'h01);
        begin
            logic [7:0] pc16 [11] = '{8'h87, 8'h5A,8'h80, 8'h91,8'h41,
                                      8'h27,8'hF9, 8'h9B,8'h42, 8'h20,8'hF6};
            for (int k = 0; k < 11; k++) poke(16'h0300 + k, pc16[k]);
        end
        mon_en  = 1'b1;
        exp_cnt = 8'h00;
        n_writes = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int t = 0; t < 5000 && n_writes < 40; t++) @(negedge clk);
        mon_en = 1'b0;
        check("R9 counter writes seen", n_writes[15:0], 16'd40);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule